// File: doc/BRIEF.md
# Halfword Flash Program and Erase Sequencer

This block manages a small on-chip nonvolatile array of 16-bit halfwords and the register interface that software uses to change it. The array lives inside the block and is organised in equal pages. It resets to the erased state, with every bit at one. Software uses a single 32-bit word-wide register port to do four things: unlock the control register with a two-word key sequence, choose an operation, start it, and poll or clear status flags. Two interrupt lines report completion and errors.

There are three operations. A program sets the program-enable field and then writes a halfword to the array window. A page erase selects a page number and sets the page-erase field together with the start bit. A mass erase sets the mass-erase field together with the start bit. Each operation holds the busy bit for a fixed, parameterised number of cycles, and the array changes when that time ends. A static input mask marks write-protected pages. An operation that would touch one of those pages is refused with a protection error. A program onto a halfword that is not erased is refused with a program error.

Address map (byte addresses): key register 0x00, status 0x04, control 0x08, erase page number 0x0C. The array window is the upper half of the address space, so halfword `i` sits at `ARR_BASE + 2*i`, which is 0x80 with the default sizes.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: After reset, status reads 0x0000_0000, control reads 0x0000_0080 (locked), both interrupt outputs are 0, and every array halfword reads 0xFFFF.
- R2: Control fields: bit 0 program enable, bit 1 page erase, bit 2 mass erase, bit 6 start, bit 7 lock, bit 10 error interrupt enable, bit 12 done interrupt enable. When lock is 0, bits 0, 1, 2, 10 and 12 are read/write. When lock is 1, every control write is ignored.
- R3: Writing 0x4567_0123 and then 0xCDEF_89AB to the key register, as two consecutive key writes, clears lock. Any other value written to the key register leaves lock unchangeable until the next reset, even if a correct sequence follows.
- R4: Lock and start are set-only from software. Writing 1 sets them, and writing 0 leaves them unchanged.
- R5: With program enable set, an unlocked and idle halfword write to an erased, unprotected location sets status bit 0 (busy) for exactly PROG_CYC cycles. When busy ends, the halfword holds old AND data and the done flag (status bit 5) is set.
- R6: A program to a halfword that is not 0xFFFF sets the program-error flag (status bit 2). Busy does not rise and the array is unchanged.
- R7: A program or page erase aimed at a page whose prot_mask bit is 1 sets the protection-error flag (status bit 4). Busy does not rise and the array is unchanged.
- R8: A control write with start=1 and page erase=1 erases the page in the page-number register. Busy lasts exactly ERASE_CYC cycles, start reads 1 during the operation and clears at its end, and the done flag is set. A start write with neither erase field set is ignored.
- R9: A control write with start=1 and mass erase=1 erases every unprotected page and leaves protected pages unchanged.
- R10: While busy is 1, array writes and start writes are ignored.
- R11: Writing 1 to status bit 2, 4 or 5 clears that flag. Writing 0 leaves it unchanged.
- R12: irq_done equals done flag AND done interrupt enable. irq_err equals (program error OR protection error) AND error interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address (8 with default sizes) |
| bus_wdata | input | 32 | Write data; array writes use bits 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| prot_mask | input | NUM_PAGES | One bit per page; 1 means write-protected |
| irq_done | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench counts busy cycles for program and erase. An off-by-one in the countdown would report PROG_CYC±1 or ERASE_CYC±1. It reprograms halfwords that are already written, which catches a design that ORs or overwrites instead of refusing with a program error. It aims operations at protected pages and runs a mass erase with a protected page that holds data, so a design that skips the protection check would lose that data. It also writes during busy, writes zeros to set-only and flag bits, and feeds a wrong key before a correct sequence. Designs that wrongly accept any of these show a changed array, a cleared flag or a cleared lock.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam logic [3:0] OFF_KEY  = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_PAGE = 4'hC;

  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_PAGE_ERASE = 2'd1,
    OP_MASS_ERASE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    KS_WAIT_FIRST  = 2'd0,
    KS_WAIT_SECOND = 2'd1,
    KS_DEAD        = 2'd2
  } key_st_e;

  typedef struct packed {
    logic done_ie;
    logic err_ie;
    logic lock;
    logic start;
    logic mass;
    logic page;
    logic prog;
  } ctrl_t;

  typedef struct packed {
    logic done;
    logic prot_err;
    logic prog_err;
  } flags_t;

endpackage

// File: rtl/nvm_key_unlock.sv
module nvm_key_unlock
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  output logic        unlock
);

  key_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      unique case (state_q)
        KS_WAIT_FIRST:  state_d = (key_data == KEY_FIRST)  ? KS_WAIT_SECOND : KS_DEAD;
        KS_WAIT_SECOND: state_d = (key_data == KEY_SECOND) ? KS_WAIT_FIRST  : KS_DEAD;
        default:        state_d = KS_DEAD;
      endcase
    end
  end

  assign unlock = key_we && (state_q == KS_WAIT_SECOND) && (key_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_WAIT_FIRST;
    else if (key_we) state_q <= state_d;
  end

  AST_KEY_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_DEAD) |=> (state_q == KS_DEAD) && !unlock); // R3

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
  import nvm_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12
)(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  launch_op,
  output logic busy,
  output logic done,
  output op_e  done_op
);

  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  op_e              op_q, op_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    op_d   = op_q;
    cnt_en = 1'b0;
    if (!busy_q && launch) begin
      cnt_en = 1'b1;
      busy_d = 1'b1;
      op_d   = launch_op;
      cnt_d  = (launch_op == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_PROG;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      op_q   <= op_d;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && (cnt_q == '0);
  assign done_op = op_q;

  AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_q); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R5

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int unsigned NUM_PAGES = 8,
  parameter int unsigned PAGE_HW   = 8,
  localparam int unsigned WORDS    = NUM_PAGES * PAGE_HW,
  localparam int unsigned IDX_W    = $clog2(WORDS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [15:0]          rd_data,
  input  logic                 prog_en,
  input  logic [IDX_W-1:0]     prog_idx,
  input  logic [15:0]          prog_data,
  input  logic                 erase_en,
  input  logic [NUM_PAGES-1:0] erase_pages
);

  logic [WORDS-1:0][15:0] mem_q, mem_d;
  logic                   upd;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int unsigned PG = w / PAGE_HW;
    assign mem_d[w] = (erase_en && erase_pages[PG]) ? 16'hFFFF :
                      (prog_en && prog_idx == IDX_W'(w)) ? (mem_q[w] & prog_data) :
                      mem_q[w];
  end

  assign upd = prog_en || erase_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mem_q <= '1;
    else if (upd) mem_q <= mem_d;
  end

  assign rd_data = mem_q[rd_idx];

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem_q[$past(prog_idx)] & ~$past(mem_q[prog_idx])) == 16'h0)); // R5

endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 8,
  parameter int unsigned PAGE_HW   = 8,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12,
  localparam int unsigned WORDS    = NUM_PAGES * PAGE_HW,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned ADDR_W   = IDX_W + 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_PAGES-1:0] prot_mask,
  output logic                 irq_done,
  output logic                 irq_err
);

  localparam int unsigned OFF_W  = ADDR_W - 1;
  localparam int unsigned PAGE_W = $clog2(NUM_PAGES);
  localparam int unsigned HW_W   = $clog2(PAGE_HW);

  // decode
  logic             arr_sel;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] arr_idx;
  logic             hit_key, hit_stat, hit_ctrl, hit_page;

  assign arr_sel  = bus_addr[ADDR_W-1];
  assign off      = bus_addr[OFF_W-1:0];
  assign arr_idx  = bus_addr[ADDR_W-2:1];
  assign hit_key  = !arr_sel && (off == OFF_W'(OFF_KEY));
  assign hit_stat = !arr_sel && (off == OFF_W'(OFF_STAT));
  assign hit_ctrl = !arr_sel && (off == OFF_W'(OFF_CTRL));
  assign hit_page = !arr_sel && (off == OFF_W'(OFF_PAGE));

  // state
  ctrl_t               ctrl_q, ctrl_d;
  flags_t              flg_q, flg_d;
  logic [PAGE_W-1:0]   page_q;
  logic [IDX_W-1:0]    pend_idx_q;
  logic [15:0]         pend_data_q;
  logic [NUM_PAGES-1:0] emask_q, emask_d;

  logic        unlock, busy, done;
  op_e         done_op, launch_op;
  logic [15:0] arr_rd;

  logic ctrl_wr, stat_wr, page_wr, key_wr, unlocked;
  logic wr_start, wr_per, wr_mer;
  logic start_req, erase_prot, launch_erase;
  logic prog_req, prog_prot, prog_dirty, launch_prog, launch;
  logic prog_en, erase_en, err_evt;

  assign unlocked = !ctrl_q.lock;
  assign ctrl_wr  = bus_we && hit_ctrl;
  assign stat_wr  = bus_we && hit_stat;
  assign page_wr  = bus_we && hit_page;
  assign key_wr   = bus_we && hit_key;

  assign wr_start = bus_wdata[6];
  assign wr_per   = bus_wdata[1];
  assign wr_mer   = bus_wdata[2];

  // erase launch
  assign start_req    = ctrl_wr && unlocked && wr_start && !busy && (wr_per || wr_mer);
  assign erase_prot   = !wr_mer && prot_mask[page_q];
  assign launch_erase = start_req && !erase_prot;

  // program launch
  assign prog_req    = bus_we && arr_sel && ctrl_q.prog && unlocked && !busy;
  assign prog_prot   = prot_mask[arr_idx[IDX_W-1:HW_W]];
  assign prog_dirty  = (arr_rd != 16'hFFFF);
  assign launch_prog = prog_req && !prog_prot && !prog_dirty;

  assign launch    = launch_prog || launch_erase;
  assign launch_op = launch_prog ? OP_PROG : (wr_mer ? OP_MASS_ERASE : OP_PAGE_ERASE);
  assign emask_d   = wr_mer ? ~prot_mask : (NUM_PAGES'(1) << page_q);

  assign prog_en  = done && (done_op == OP_PROG);
  assign erase_en = done && (done_op != OP_PROG);
  assign err_evt  = (start_req && erase_prot) || (prog_req && (prog_prot || prog_dirty));

  // control next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr && unlocked) begin
      ctrl_d.prog    = bus_wdata[0];
      ctrl_d.page    = wr_per;
      ctrl_d.mass    = wr_mer;
      ctrl_d.err_ie  = bus_wdata[10];
      ctrl_d.done_ie = bus_wdata[12];
      if (bus_wdata[7]) ctrl_d.lock = 1'b1;
    end
    if (launch_erase) ctrl_d.start = 1'b1;
    else if (erase_en) ctrl_d.start = 1'b0;
    if (unlock) ctrl_d.lock = 1'b0;
  end

  // status next state: hardware set wins over software clear
  always_comb begin
    flg_d = flg_q;
    if (stat_wr) begin
      if (bus_wdata[2]) flg_d.prog_err = 1'b0;
      if (bus_wdata[4]) flg_d.prot_err = 1'b0;
      if (bus_wdata[5]) flg_d.done     = 1'b0;
    end
    if ((start_req && erase_prot) || (prog_req && prog_prot)) flg_d.prot_err = 1'b1;
    if (prog_req && !prog_prot && prog_dirty)                  flg_d.prog_err = 1'b1;
    if (done)                                                  flg_d.done     = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{lock: 1'b1, default: 1'b0};
      flg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flg_q  <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_wr) page_q <= bus_wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx_q  <= '0;
      pend_data_q <= '0;
    end else if (launch_prog) begin
      pend_idx_q  <= arr_idx;
      pend_data_q <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            emask_q <= '0;
    else if (launch_erase) emask_q <= emask_d;
  end

  // read mux
  always_comb begin
    bus_rdata = 32'h0;
    if (arr_sel)       bus_rdata = {16'h0, arr_rd};
    else if (hit_stat) bus_rdata = {26'h0, flg_q.done, flg_q.prot_err, 1'b0, flg_q.prog_err, 1'b0, busy};
    else if (hit_ctrl) bus_rdata = {19'h0, ctrl_q.done_ie, 1'b0, ctrl_q.err_ie, 2'b00,
                                    ctrl_q.lock, ctrl_q.start, 3'b000,
                                    ctrl_q.mass, ctrl_q.page, ctrl_q.prog};
    else if (hit_page) bus_rdata = 32'(page_q);
  end

  assign irq_done = flg_q.done && ctrl_q.done_ie;
  assign irq_err  = (flg_q.prog_err || flg_q.prot_err) && ctrl_q.err_ie;

  nvm_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_wr),
    .key_data (bus_wdata),
    .unlock   (unlock)
  );

  nvm_op_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .launch_op (launch_op),
    .busy      (busy),
    .done      (done),
    .done_op   (done_op)
  );

  nvm_array #(.NUM_PAGES(NUM_PAGES), .PAGE_HW(PAGE_HW)) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (arr_idx),
    .rd_data     (arr_rd),
    .prog_en     (prog_en),
    .prog_idx    (pend_idx_q),
    .prog_data   (pend_data_q),
    .erase_en    (erase_en),
    .erase_pages (emask_q)
  );

  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.start |-> busy); // R8
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.lock && !unlock) |=> $stable({ctrl_q.prog, ctrl_q.page, ctrl_q.mass,
                                          ctrl_q.err_ie, ctrl_q.done_ie, ctrl_q.lock})); // R2
  AST_IRQ_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (ctrl_q.done_ie && flg_q.done)); // R12
  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy); // R7

endmodule

// File: tb/nvm_flash_ctrl_tb.sv
module nvm_flash_ctrl_tb_top;

  localparam int NP = 8, PH = 8, PC = 4, EC = 12;
  localparam int WORDS = NP * PH;
  localparam int AW = $clog2(WORDS) + 2;
  localparam logic [AW-1:0] ARR_BASE = AW'(1) << (AW - 1);

  logic          clk, rst_n, bus_we, irq_done, irq_err;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] prot_mask;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] model [WORDS];

  nvm_flash_ctrl #(.NUM_PAGES(NP), .PAGE_HW(PH), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_mask(prot_mask),
    .irq_done(irq_done), .irq_err(irq_err));

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [AW-1:0] arr_addr(int idx);
    return ARR_BASE + AW'(2 * idx);
  endfunction

  function automatic bit page_prot(int idx);
    return prot_mask[idx / PH];
  endfunction

  function automatic logic [15:0] exp_prog(logic [15:0] old_v, logic [15:0] dat);
    return old_v & dat;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] s;
    n = 0;
    rd(AW'(4), s);
    while (s[0] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(AW'(4), s);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    int unsigned seed;
    seed = $urandom(32'd4242);
    bus_we = 0; bus_addr = '0; bus_wdata = '0;
    prot_mask = 8'b1000_0001;
    rst_n = 0;
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(AW'(4), v); chk("R1 status", v, 32'h0);
    rd(AW'(8), v); chk("R1 control", v, 32'h80);
    chk("R1 irqs", {30'h0, irq_done, irq_err}, 32'h0);
    for (int i = 0; i < WORDS; i += 9) begin rd(arr_addr(i), v); chk("R1 array", v, 32'hFFFF); end

    // R2 locked writes ignored
    wr(AW'(8), 32'h1401); rd(AW'(8), v); chk("R2 locked", v, 32'h80);

    // R3 unlock
    wr(AW'(0), 32'h4567_0123); wr(AW'(0), 32'hCDEF_89AB);
    rd(AW'(8), v); chk("R3 unlocked", v, 32'h0);

    // R8 start without erase select ignored
    wr(AW'(8), 32'h40); rd(AW'(8), v); chk("R8 bare start", v, 32'h0);
    rd(AW'(4), v); chk("R8 bare start no busy", v, 32'h0);

    // R2 rw fields
    wr(AW'(8), 32'h1401); rd(AW'(8), v); chk("R2 rw fields", v, 32'h1401);

    // R5 directed program
    wr(arr_addr(10), 32'h0000_A5A5);
    busy_len(n); chk("R5 program busy cycles", n, PC);
    model[10] = exp_prog(16'hFFFF, 16'hA5A5);
    rd(arr_addr(10), v); chk("R5 program value", v, {16'h0, model[10]});
    rd(AW'(4), v); chk("R5 done flag", v, 32'h20);
    chk("R12 irq_done on", irq_done, 1);

    // R11 write-one-to-clear
    wr(AW'(4), 32'h0); rd(AW'(4), v); chk("R11 write zero keeps", v, 32'h20);
    wr(AW'(4), 32'h20); rd(AW'(4), v); chk("R11 write one clears", v, 32'h0);
    chk("R12 irq_done off", irq_done, 0);

    // R6 program onto written halfword
    wr(arr_addr(10), 32'h0F0F);
    rd(AW'(4), v); chk("R6 prog error no busy", v, 32'h04);
    chk("R12 irq_err on", irq_err, 1);
    rd(arr_addr(10), v); chk("R6 array unchanged", v, {16'h0, model[10]});
    wr(AW'(4), 32'h04); rd(AW'(4), v); chk("R11 clear prog error", v, 32'h0);

    // R7 program on protected page
    wr(arr_addr(3), 32'h0000);
    rd(AW'(4), v); chk("R7 prot error no busy", v, 32'h10);
    rd(arr_addr(3), v); chk("R7 array unchanged", v, 32'hFFFF);
    wr(AW'(4), 32'h10);

    // R5/R6 random programs in pages 3..6
    for (int k = 0; k < 30; k++) begin
      int idx;
      logic [15:0] d;
      idx = 24 + int'($urandom_range(31));
      d = 16'($urandom);
      wr(arr_addr(idx), {16'h0, d});
      if (model[idx] != 16'hFFFF) begin
        rd(AW'(4), v); chk("R6 random prog error", v, 32'h04);
      end else begin
        busy_len(n); chk("R5 random busy", n, PC);
        model[idx] = exp_prog(model[idx], d);
        rd(AW'(4), v); chk("R5 random done", v, 32'h20);
      end
      rd(arr_addr(idx), v); chk("R5 random value", v, {16'h0, model[idx]});
      wr(AW'(4), 32'h34);
    end

    // R10 writes during busy ignored
    wr(arr_addr(20), 32'h00FF);
    wr(arr_addr(21), 32'h0000);
    wr(AW'(8), 32'h1443);
    rd(AW'(8), v); chk("R10 start ignored while busy", v, 32'h1403);
    busy_len(n);
    model[20] = 16'h00FF;
    rd(arr_addr(20), v); chk("R10 first program done", v, 32'h00FF);
    rd(arr_addr(21), v); chk("R10 busy array write ignored", v, 32'hFFFF);
    rd(arr_addr(16), v); chk("R10 busy erase ignored", v, 32'hFFFF);
    rd(arr_addr(20), v); chk("R10 page 2 not erased", v, 32'h00FF);
    wr(AW'(4), 32'h34);

    // R8 page erase
    wr(AW'(12), 32'h2);
    wr(AW'(8), 32'h1442);
    rd(AW'(8), v); chk("R8 start visible", v, 32'h1442);
    busy_len(n); chk("R8 erase busy cycles", n, EC);
    rd(AW'(8), v); chk("R8 start self-clears", v, 32'h1402);
    rd(AW'(4), v); chk("R8 done flag", v, 32'h20);
    for (int i = 16; i < 24; i++) model[i] = 16'hFFFF;
    rd(arr_addr(20), v); chk("R8 page erased", v, 32'hFFFF);
    rd(arr_addr(10), v); chk("R8 other page kept", v, {16'h0, model[10]});
    wr(AW'(4), 32'h20);

    // R7 protected page erase
    wr(AW'(12), 32'h7);
    wr(AW'(8), 32'h1442);
    rd(AW'(4), v); chk("R7 erase prot error", v, 32'h10);
    rd(AW'(8), v); chk("R7 no start", v, 32'h1402);
    chk("R12 irq_err prot", irq_err, 1);
    wr(AW'(4), 32'h10);

    // R9 mass erase keeps protected data
    prot_mask = 8'h00;
    wr(AW'(8), 32'h1401);
    wr(arr_addr(1), 32'h1234);
    busy_len(n);
    model[1] = 16'h1234;
    wr(AW'(4), 32'h20);
    prot_mask = 8'b1000_0001;
    wr(AW'(8), 32'h1444);
    busy_len(n); chk("R9 mass busy cycles", n, EC);
    for (int i = 0; i < WORDS; i++) if (!page_prot(i)) model[i] = 16'hFFFF;
    rd(arr_addr(1), v); chk("R9 protected kept", v, 32'h1234);
    for (int i = 8; i < 56; i += 5) begin rd(arr_addr(i), v); chk("R9 unprotected erased", v, {16'h0, model[i]}); end

    // R12 gating with flag still set
    wr(AW'(8), 32'h0);
    rd(AW'(4), v); chk("R12 done flag held", v, 32'h20);
    chk("R12 irq_done masked", irq_done, 0);

    // R4 set-only lock
    wr(AW'(8), 32'h80); rd(AW'(8), v); chk("R4 lock set", v, 32'h80);
    wr(AW'(8), 32'h0);  rd(AW'(8), v); chk("R4 lock zero ignored", v, 32'h80);
    wr(AW'(8), 32'h1401); rd(AW'(8), v); chk("R2 relocked ignored", v, 32'h80);

    // R3 wrong key then correct sequence stays locked
    wr(AW'(0), 32'h1111_1111);
    wr(AW'(0), 32'h4567_0123); wr(AW'(0), 32'hCDEF_89AB);
    rd(AW'(8), v); chk("R3 wrong key locks", v, 32'h80);

    finish_run();
  end

endmodule